// File: doc/BRIEF.md
# System Management Interrupt Controller

This block accepts an active-low, level-sensitive management interrupt request from a shared open-drain pad. It arbitrates that request against a non-maskable interrupt. The pad sample passes through a synchronizer. The request is taken only after it has stayed low for a minimum run of clock periods. When the request wins, the block pulses an acknowledge, raises an in-mode flag, and drives the same pad low for as long as the service routine runs. A single exit pulse ends the mode and releases the pad.

While the block is in management mode, each bus cycle start produces the management address strobe instead of the normal one. The management strobe is only driven after configuration software has set the enable bit. It floats whenever the bus is handed to another master. Until the enable bit is set, the request pad is ignored.

Top module: `mgmt_irq_ctrl`

## Requirements
- R1: The request is active low. The pad is sampled through a two-stage synchronizer. When the pad falls to 0 before clock edge E1 and stays low, `mgmt_ack_o` is 1 for exactly one cycle, after edge E6, and `in_mode_o` goes to 1 at that same edge.
- R2: The request is taken only after the synchronized pad has been 0 for 4 consecutive clocks. A low pulse that covers fewer than 4 edges produces no acknowledge. Any return to 1 restarts the count, so two 3-cycle pulses separated by a high cycle produce no acknowledge.
- R3: `nmi_ack_o` pulses for one cycle, 2 edges after a rising edge on `nmi_req_i`. The two acknowledges never occur in the same cycle. If the NMI becomes pending in the same cycle that the management request qualifies, only `mgmt_ack_o` fires. The NMI stays pending, unacknowledged, for the whole mode and is acknowledged one edge after the mode is left.
- R4: While `in_mode_o` is 1, the block drives the pad: `req_pad_oe` = 1 and `req_pad_o` = 0. An `exit_i` pulse during the mode clears `in_mode_o` and `req_pad_oe` at the next edge. An `exit_i` pulse outside the mode has no effect.
- R5: While `mgmt_en_i` = 0, no low level on the pad, however long, produces `mgmt_ack_o`.
- R6: After the mode is left, a new request is accepted only once the synchronized pad has been seen at 1. A pad still held low across the exit produces no further acknowledge until it goes high and then low again for the full qualification run.
- R7: A `cyc_start_i` pulse outside the mode makes `astb_n_o` 0 for the following cycle only, with `mstb_n_o` staying at 1. Inside the mode, the pulse makes `mstb_n_o` 0 for that cycle instead, with `astb_n_o` staying at 1. The two strobes are never low together.
- R8: `mstb_oe` is 1 only when `mgmt_en_i` = 1 and `hold_ack_i` = 0. `astb_oe` is the inverse of `hold_ack_i`. Both follow their inputs in the same cycle.
- R9: During reset the outputs are as follows: `in_mode_o` = 0, both acknowledges = 0, `req_pad_oe` = 0, `astb_n_o` = `mstb_n_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_pad_i | input | 1 | Sampled level of the shared request pad (0 = request) |
| nmi_req_i | input | 1 | Non-maskable interrupt request, rising edge taken |
| mgmt_en_i | input | 1 | Configuration enable for the management interrupt and strobe |
| cyc_start_i | input | 1 | One-cycle bus cycle start pulse |
| hold_ack_i | input | 1 | Bus granted to another master |
| exit_i | input | 1 | One-cycle service routine exit pulse |
| req_pad_o | output | 1 | Value driven onto the request pad (0 while in mode) |
| req_pad_oe | output | 1 | Output enable for the request pad |
| astb_n_o | output | 1 | Normal address strobe, active low |
| astb_oe | output | 1 | Output enable for the normal strobe |
| mstb_n_o | output | 1 | Management address strobe, active low |
| mstb_oe | output | 1 | Output enable for the management strobe |
| mgmt_ack_o | output | 1 | One-cycle management interrupt acknowledge |
| nmi_ack_o | output | 1 | One-cycle NMI acknowledge |
| in_mode_o | output | 1 | Management mode active |

## Verification
The acknowledge of the management request is due six edges after the pad falls: two synchronizer edges, three counting edges, and one register edge. The NMI acknowledge is due two edges after the request rises. The strobes are due one edge after the start pulse, and leaving the mode takes one edge after exit. The output enables follow their inputs combinationally. The bench drives inputs on falling edges and samples on the next falling edge. It numbers each rising edge after a stimulus and compares every output in every cycle of a window against the value computed for that edge number. For example, in the sweep over low-pulse lengths 1 to 7, the acknowledge is expected only in cycle 6 and only when the length is at least 4.

// File: rtl/mgmt_irq_pkg.sv
// Package: shared types and helpers for the management interrupt controller.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package mgmt_irq_pkg;

    // Operating mode of the controller.
    typedef enum logic [0:0] {
        MODE_NORMAL  = 1'b0,
        MODE_SERVICE = 1'b1
    } mode_e;

    // Width needed to hold a run counter reaching n-1, at least one bit.
    function automatic int run_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/mgmt_req_qual.sv
// Module: request qualifier. Synchronizes the active-low pad, counts
// consecutive low samples and raises req_o once the run reaches QUAL_CYCLES.
// Assumes: mask_i is high while the block itself drives the pad; after the
// mask drops, the pad must be seen high before a new run can count.
module mgmt_req_qual
    import mgmt_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_i,
    input  logic enable_i,
    input  logic mask_i,
    output logic req_o
);

    localparam int RW = run_width(QUAL_CYCLES);
    localparam logic [RW-1:0] RUN_TOP = RW'(QUAL_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pad_low;
    logic                   armed_q;
    logic                   active;
    logic [RW-1:0]          run_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            // Single-stage pad capture.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= pad_i;
            end
        end else begin : g_sync_chain
            // Multi-stage pad synchronizer shifting toward the MSB.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i};
            end
        end
    endgenerate

    assign pad_low = ~sync_q[SYNC_STAGES-1];
    assign active  = pad_low && armed_q && enable_i && !mask_i;

    // Arm flag: dropped while masked, set again once the pad reads high.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed_q <= 1'b1;
        else if (mask_i)   armed_q <= 1'b0;
        else if (!pad_low) armed_q <= 1'b1;
    end

    // Run counter of consecutive qualified low samples, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)              run_q <= '0;
        else if (!active)        run_q <= '0;
        else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
    end

    assign req_o = active && (run_q == RUN_TOP);

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |-> !req_o);

    generate
        if (QUAL_CYCLES == 4) begin : g_run_chk
            assert_full_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
                req_o |-> ($past(pad_low, 1) && $past(pad_low, 2) && $past(pad_low, 3)));
        end
    endgenerate

endmodule

// File: rtl/mgmt_mode_fsm.sv
// Module: mode state machine and interrupt arbiter. Gives the qualified
// management request priority over a pending NMI and holds the mode until exit.
// Assumes: req_i drops on its own once mode is entered (qualifier is masked).
module mgmt_mode_fsm
    import mgmt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic nmi_req_i,
    input  logic exit_i,
    output logic in_mode_o,
    output logic mgmt_ack_o,
    output logic nmi_ack_o
);

    mode_e state_q;
    logic  nmi_prev_q;
    logic  nmi_pend_q;
    logic  nmi_rise;
    logic  nmi_take;
    logic  mgmt_take;

    assign nmi_rise  = nmi_req_i && !nmi_prev_q;
    assign mgmt_take = (state_q == MODE_NORMAL) && req_i;
    assign nmi_take  = (state_q == MODE_NORMAL) && !req_i && nmi_pend_q;

    // Mode register: enter on a qualified request, leave on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_NORMAL;
        end else begin
            case (state_q)
                MODE_NORMAL:  if (req_i)  state_q <= MODE_SERVICE;
                MODE_SERVICE: if (exit_i) state_q <= MODE_NORMAL;
                default:                  state_q <= MODE_NORMAL;
            endcase
        end
    end

    // NMI edge detect and pending latch, cleared when acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_req_i;
            nmi_pend_q <= (nmi_pend_q && !nmi_take) || nmi_rise;
        end
    end

    // Registered one-cycle acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mgmt_ack_o <= 1'b0;
            nmi_ack_o  <= 1'b0;
        end else begin
            mgmt_ack_o <= mgmt_take;
            nmi_ack_o  <= nmi_take;
        end
    end

    assign in_mode_o = (state_q == MODE_SERVICE);

    assert_ack_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mgmt_ack_o, nmi_ack_o}));
    assert_nmi_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mode_o && $past(in_mode_o)) |-> !nmi_ack_o);
    assert_ack_enters_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_ack_o |-> in_mode_o);
    assert_exit_leaves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mode_o && exit_i) |=> !in_mode_o);

endmodule

// File: rtl/mgmt_strobe_steer.sv
// Module: address strobe steering. Turns a cycle start pulse into a one-cycle
// active-low strobe on the normal or the management output, by mode.
// Assumes: mode_i is stable at the edge that samples cyc_start_i.
module mgmt_strobe_steer (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start_i,
    input  logic mode_i,
    input  logic hold_ack_i,
    input  logic enable_i,
    output logic astb_n_o,
    output logic astb_oe_o,
    output logic mstb_n_o,
    output logic mstb_oe_o
);

    // Registered strobes, one cycle after the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            astb_n_o <= 1'b1;
            mstb_n_o <= 1'b1;
        end else begin
            astb_n_o <= !(cyc_start_i && !mode_i);
            mstb_n_o <= !(cyc_start_i && mode_i);
        end
    end

    // Output enables: float on hold, management strobe also needs enable.
    always_comb begin
        astb_oe_o = !hold_ack_i;
        mstb_oe_o = enable_i && !hold_ack_i;
    end

    assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!astb_n_o && !mstb_n_o));
    assert_mstb_from_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mstb_n_o |-> ($past(mode_i) && $past(cyc_start_i)));
    assert_mstb_float_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack_i |-> (!mstb_oe_o && !astb_oe_o));

endmodule

// File: rtl/mgmt_irq_ctrl.sv
// Module: top of the management interrupt controller. Connects the request
// qualifier, the mode/arbiter state machine and the strobe steering, and
// drives the shared request pad low while in management mode.
// Assumes: the pad is open drain; req_pad_i reads the wired level.
module mgmt_irq_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_pad_i,
    input  logic nmi_req_i,
    input  logic mgmt_en_i,
    input  logic cyc_start_i,
    input  logic hold_ack_i,
    input  logic exit_i,
    output logic req_pad_o,
    output logic req_pad_oe,
    output logic astb_n_o,
    output logic astb_oe,
    output logic mstb_n_o,
    output logic mstb_oe,
    output logic mgmt_ack_o,
    output logic nmi_ack_o,
    output logic in_mode_o
);

    logic qual_req;
    logic in_mode;

    mgmt_req_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .QUAL_CYCLES (QUAL_CYCLES)
    ) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_i    (req_pad_i),
        .enable_i (mgmt_en_i),
        .mask_i   (in_mode),
        .req_o    (qual_req)
    );

    mgmt_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (qual_req),
        .nmi_req_i  (nmi_req_i),
        .exit_i     (exit_i),
        .in_mode_o  (in_mode),
        .mgmt_ack_o (mgmt_ack_o),
        .nmi_ack_o  (nmi_ack_o)
    );

    mgmt_strobe_steer u_steer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start_i (cyc_start_i),
        .mode_i      (in_mode),
        .hold_ack_i  (hold_ack_i),
        .enable_i    (mgmt_en_i),
        .astb_n_o    (astb_n_o),
        .astb_oe_o   (astb_oe),
        .mstb_n_o    (mstb_n_o),
        .mstb_oe_o   (mstb_oe)
    );

    // Pad drive: pull low for the whole service routine.
    always_comb begin
        req_pad_oe = in_mode;
        req_pad_o  = !in_mode;
        in_mode_o  = in_mode;
    end

    assert_pad_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pad_oe && !exit_i) |=> (req_pad_oe && !req_pad_o));
    assert_no_ack_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mgmt_en_i) |-> !mgmt_ack_o);

endmodule

// File: tb/mgmt_irq_ctrl_bench.sv
module mgmt_irq_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n, ext_lvl, nmi, en, cyc, hold, ex;
    logic pad;
    logic req_pad_o, req_pad_oe, astb_n_o, astb_oe, mstb_n_o, mstb_oe;
    logic mgmt_ack_o, nmi_ack_o, in_mode_o;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #10 clk = ~clk;

    assign pad = ext_lvl & (req_pad_oe ? req_pad_o : 1'b1);

    mgmt_irq_ctrl u_mgmt_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_pad_i(pad), .nmi_req_i(nmi),
        .mgmt_en_i(en), .cyc_start_i(cyc), .hold_ack_i(hold), .exit_i(ex),
        .req_pad_o(req_pad_o), .req_pad_oe(req_pad_oe), .astb_n_o(astb_n_o),
        .astb_oe(astb_oe), .mstb_n_o(mstb_n_o), .mstb_oe(mstb_oe),
        .mgmt_ack_o(mgmt_ack_o), .nmi_ack_o(nmi_ack_o), .in_mode_o(in_mode_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Low pulse of L edges from idle; ack due after edge 6 when L >= 4.
    task automatic run_pulse(input int len);
        bit took;
        took = (len >= 4);
        ext_lvl = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            tick();
            if (k == len) ext_lvl = 1'b1;
            check("R1 ack timing", mgmt_ack_o, (took && k == 6) ? 1 : 0);
            check("R2 in_mode", in_mode_o, (took && k >= 6) ? 1 : 0);
            check("R4 pad drive", req_pad_oe && !req_pad_o, (took && k >= 6) ? 1 : 0);
        end
        if (took) begin
            ex = 1'b1;
            tick();
            ex = 1'b0;
            check("R4 exit clears mode", in_mode_o, 0);
            check("R4 exit releases pad", req_pad_oe, 0);
        end
        repeat (4) tick();
    endtask

    task automatic enter_mode();
        ext_lvl = 1'b0;
        repeat (6) tick();
        ext_lvl = 1'b1;
        check("R1 entered mode", in_mode_o, 1);
    endtask

    initial begin
        rst_n = 1'b0; ext_lvl = 1'b1; nmi = 1'b0; en = 1'b0;
        cyc = 1'b0; hold = 1'b0; ex = 1'b0;
        repeat (3) tick();
        // R9 reset state
        check("R9 in_mode", in_mode_o, 0);
        check("R9 mgmt_ack", mgmt_ack_o, 0);
        check("R9 nmi_ack", nmi_ack_o, 0);
        check("R9 pad oe", req_pad_oe, 0);
        check("R9 astb_n", astb_n_o, 1);
        check("R9 mstb_n", mstb_n_o, 1);
        rst_n = 1'b1;
        tick();

        // R5: disabled, long low level ignored
        ext_lvl = 1'b0;
        for (int k = 0; k < 10; k++) begin
            tick();
            check("R5 no ack while disabled", mgmt_ack_o, 0);
            check("R8 mstb_oe while disabled", mstb_oe, 0);
        end
        ext_lvl = 1'b1;
        repeat (4) tick();
        en = 1'b1;
        tick();
        check("R8 mstb_oe enabled", mstb_oe, 1);

        // R4: exit outside the mode has no effect
        ex = 1'b1;
        tick();
        ex = 1'b0;
        check("R4 stray exit mode", in_mode_o, 0);
        check("R4 stray exit pad", req_pad_oe, 0);

        // R1/R2: sweep low-pulse length
        for (int len = 1; len <= 7; len++) run_pulse(len);

        // R2: two 3-cycle pulses split by one high cycle
        ext_lvl = 1'b0;
        for (int k = 1; k <= 14; k++) begin
            tick();
            if (k == 3) ext_lvl = 1'b1;
            if (k == 4) ext_lvl = 1'b0;
            if (k == 7) ext_lvl = 1'b1;
            check("R2 restart no ack", mgmt_ack_o, 0);
        end
        repeat (3) tick();

        // R3: plain NMI, ack after 2 edges
        nmi = 1'b1;
        tick();
        check("R3 nmi early", nmi_ack_o, 0);
        tick();
        check("R3 nmi ack", nmi_ack_o, 1);
        tick();
        check("R3 nmi pulse", nmi_ack_o, 0);
        nmi = 1'b0;
        repeat (2) tick();

        // R3: same-cycle conflict, management wins, NMI deferred
        ext_lvl = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            tick();
            if (k == 4) nmi = 1'b1;
            if (k == 6) ext_lvl = 1'b1;
            check("R3 mgmt ack", mgmt_ack_o, (k == 6) ? 1 : 0);
            check("R3 nmi deferred", nmi_ack_o, 0);
        end
        ex = 1'b1;
        tick();
        ex = 1'b0;
        check("R3 left mode", in_mode_o, 0);
        check("R3 nmi not yet", nmi_ack_o, 0);
        tick();
        check("R3 nmi after exit", nmi_ack_o, 1);
        tick();
        check("R3 nmi single", nmi_ack_o, 0);
        nmi = 1'b0;
        repeat (3) tick();

        // R6: pad held low across exit, no re-entry until high then low
        ext_lvl = 1'b0;
        for (int k = 1; k <= 10; k++) begin
            tick();
            check("R6 first ack", mgmt_ack_o, (k == 6) ? 1 : 0);
        end
        ex = 1'b1;
        tick();
        ex = 1'b0;
        for (int k = 0; k < 10; k++) begin
            tick();
            check("R6 no re-ack while low", mgmt_ack_o, 0);
            check("R6 stays out", in_mode_o, 0);
        end
        ext_lvl = 1'b1;
        repeat (3) tick();
        ext_lvl = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            tick();
            if (k == 6) ext_lvl = 1'b1;
            check("R6 re-ack after high", mgmt_ack_o, (k == 6) ? 1 : 0);
        end
        ex = 1'b1;
        tick();
        ex = 1'b0;
        repeat (3) tick();

        // R7: strobe steering outside mode
        cyc = 1'b1;
        tick();
        cyc = 1'b0;
        check("R7 astb low", astb_n_o, 0);
        check("R7 mstb high", mstb_n_o, 1);
        tick();
        check("R7 astb one cycle", astb_n_o, 1);

        // R7: inside mode
        enter_mode();
        cyc = 1'b1;
        tick();
        cyc = 1'b0;
        check("R7 mstb low in mode", mstb_n_o, 0);
        check("R7 astb high in mode", astb_n_o, 1);
        tick();
        check("R7 mstb one cycle", mstb_n_o, 1);

        // R8: hold floats both strobes
        hold = 1'b1;
        tick();
        check("R8 mstb_oe hold", mstb_oe, 0);
        check("R8 astb_oe hold", astb_oe, 0);
        hold = 1'b0;
        tick();
        check("R8 mstb_oe released", mstb_oe, 1);
        check("R8 astb_oe released", astb_oe, 1);
        ex = 1'b1;
        tick();
        ex = 1'b0;
        check("R4 final exit", in_mode_o, 0);
        repeat (2) tick();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

endmodule